// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and the calendar date as packed binary-coded decimal. It runs from a single 32.768 kHz clock. An internal prescaler turns that clock into one advance per second. Each advance can ripple from seconds through minutes, hours, date, month and year. The day of week steps whenever the date steps. The date roll respects month lengths and the leap rule of a two-digit year.

A bus interface loads any of the seven time registers through a single-cycle write port. The whole time set is visible at once on seven parallel byte outputs.

Hours can be held in 24-hour form, or in 12-hour form with an afternoon flag. A halt bit kept in the seconds register freezes both the time fields and the prescaler. An asynchronous active-low reset loads the cold-start time.

Top module: `rtc_clock_cal`

## Requirements
- R1: While reset is low, and after its release until the first advance, the registers read: seconds 0x00 (halt bit clear), minutes 0x00, hours 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01, year 0x00.
- R2: Seconds and minutes count in BCD from 00 to 59. A seconds wrap advances the minutes, and a minutes wrap advances the hours. One second passes every TICK_DIV clock cycles, the first one TICK_DIV cycles after reset release.
- R3: In 24-hour mode (hours bit 6 = 0), hours count 00 to 23 in bits 5:0. Going from 23:59:59 to 00:00:00 advances the date.
- R4: In 12-hour mode (hours bit 6 = 1), hours count 12, 01 … 11 in bits 4:0, and bit 5 is the afternoon flag. The flag toggles when the hour goes from 11 to 12. Going from 11:59:59 with the flag set to 12:00:00 with the flag clear advances the date. Bit 6 is kept throughout.
- R5: Months 04, 06, 09 and 11 roll from date 30 to 01. The other months except 02 roll from 31 to 01. A date roll advances the month.
- R6: February rolls after date 29 when the BCD year is divisible by four (00 counts as divisible), and after date 28 otherwise.
- R7: Month 12 rolls to 01 and advances the year. Year 99 rolls to 00.
- R8: Day of week counts 1 to 7 and returns to 1. It advances on every date advance.
- R9: While seconds bit 7 (halt) is 1, no time field changes and the prescaler holds its count. Clearing the bit lets counting resume.
- R10: With the write enable high, the addressed register is loaded at the next clock edge. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Address 7 changes nothing. An advance that falls on a write cycle is dropped.
- R11: A write to the seconds register clears the prescaler, so the next advance comes exactly TICK_DIV cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32.768 kHz counting clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index for the write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode bit, afternoon flag and BCD hours |
| dow_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | BCD date of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD two-digit year |

## Verification
The bench builds the block with TICK_DIV = 4, so one second lasts four clock cycles. Every carry chain can then be reached within a few cycles: from seconds through to the year, the leap February cases, and both hour modes. Each case is preloaded while halted, then released with a seconds write that also aligns the prescaler, so the cycle of every expected advance is known exactly. Directed tests then exercise halt, the unused address, an advance dropped by a coinciding write, and the prescaler realignment.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HOUR = 3'd2,
    RA_DOW  = 3'd3,
    RA_DATE = 3'd4,
    RA_MON  = 3'd5,
    RA_YEAR = 3'd6
  } reg_addr_e;

  // Add one to a two-digit packed BCD value (caller handles the upper wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Two-digit BCD year divisible by four: even tens with ones 0/4/8,
  // odd tens with ones 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_en = clr_i || run_i;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr_i)       cnt_nx = '0;
    else if (tick_o) cnt_nx = '0;
    else if (run_i)  cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  // R11
  div_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  // R9
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [7:0] hour_i,
  output logic [7:0] hour_o,
  output logic       day_o
);
  import rtc_cal_pkg::*;

  logic [7:0] inc12, inc24;
  logic       pm;

  assign pm    = hour_i[5];
  assign inc12 = bcd_inc({3'b000, hour_i[4:0]});
  assign inc24 = bcd_inc({2'b00, hour_i[5:0]});

  always_comb begin
    hour_o = hour_i;
    day_o  = 1'b0;
    if (hour_i[6]) begin
      if (hour_i[4:0] == 5'h11) begin
        hour_o = {2'b01, ~pm, 5'h12};
        day_o  = pm;
      end else if (hour_i[4:0] == 5'h12) begin
        hour_o = {2'b01, pm, 5'h01};
      end else begin
        hour_o = {2'b01, pm, inc12[4:0]};
      end
    end else begin
      if (hour_i[5:0] == 6'h23) begin
        hour_o = 8'h00;
        day_o  = 1'b1;
      end else begin
        hour_o = {2'b00, inc24[5:0]};
      end
    end
  end

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_o
);
  import rtc_cal_pkg::*;

  always_comb begin
    case (mon_i)
      8'h02:                      last_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/rtc_clock_cal.sv
module rtc_clock_cal #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  import rtc_cal_pkg::*;

  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
  logic [7:0] sec_nx, min_nx, hour_nx, dow_nx, date_nx, mon_nx, year_nx;
  logic [7:0] hour_adv, last_date;
  logic       tick, tick_eff, sec_clr, day_wrap, upd_en;
  logic       adv_min, adv_hour, adv_day, adv_mon, adv_year;

  assign sec_clr = wr_en_i && (wr_addr_i == RA_SEC);

  rtc_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (~sec_q[7]),
    .clr_i  (sec_clr),
    .tick_o (tick)
  );

  rtc_hour_step u_hour (
    .hour_i (hour_q),
    .hour_o (hour_adv),
    .day_o  (day_wrap)
  );

  rtc_month_len u_mlen (
    .mon_i  (mon_q),
    .year_i (year_q),
    .last_o (last_date)
  );

  // A write owns its cycle; a coinciding advance is dropped.
  assign tick_eff = tick && !wr_en_i;
  assign adv_min  = tick_eff && (sec_q[6:0] == 7'h59);
  assign adv_hour = adv_min  && (min_q[6:0] == 7'h59);
  assign adv_day  = adv_hour && day_wrap;
  assign adv_mon  = adv_day  && (date_q == last_date);
  assign adv_year = adv_mon  && (mon_q == 8'h12);
  assign upd_en   = wr_en_i || tick_eff;

  always_comb begin
    sec_nx  = sec_q;
    min_nx  = min_q;
    hour_nx = hour_q;
    dow_nx  = dow_q;
    date_nx = date_q;
    mon_nx  = mon_q;
    year_nx = year_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        RA_SEC:  sec_nx  = wr_data_i;
        RA_MIN:  min_nx  = {1'b0, wr_data_i[6:0]};
        RA_HOUR: hour_nx = {1'b0, wr_data_i[6:0]};
        RA_DOW:  dow_nx  = {5'b0, wr_data_i[2:0]};
        RA_DATE: date_nx = {2'b0, wr_data_i[5:0]};
        RA_MON:  mon_nx  = {3'b0, wr_data_i[4:0]};
        RA_YEAR: year_nx = wr_data_i;
        default: ;
      endcase
    end else if (tick_eff) begin
      sec_nx = adv_min ? 8'h00 : bcd_inc(sec_q);
      if (adv_min)  min_nx  = adv_hour ? 8'h00 : bcd_inc(min_q);
      if (adv_hour) hour_nx = hour_adv;
      if (adv_day) begin
        dow_nx  = (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
        date_nx = adv_mon ? 8'h01 : bcd_inc(date_q);
      end
      if (adv_mon)  mon_nx  = adv_year ? 8'h01 : bcd_inc(mon_q);
      if (adv_year) year_nx = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (upd_en) begin
      sec_q  <= sec_nx;
      min_q  <= min_nx;
      hour_q <= hour_nx;
      dow_q  <= dow_nx;
      date_q <= date_nx;
      mon_q  <= mon_nx;
      year_q <= year_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign dow_o  = dow_q;
  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

  // R9
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q[7] && !wr_en_i) |=> (sec_q == $past(sec_q) && min_q == $past(min_q) &&
                                hour_q == $past(hour_q) && date_q == $past(date_q)));

  // R2
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_en_i && sec_q[6:0] == 7'h59) |=> (sec_q == 8'h00 && min_q != $past(min_q)));

  // R8
  dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_day && dow_q == 8'h07) |=> (dow_q == 8'h01));

  // R5
  date_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_mon |=> (date_q == 8'h01 && mon_q != $past(mon_q)));

  // R10
  year_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd6) |=> (year_q == $past(wr_data_i)));

endmodule

// File: tb/rtc_clock_cal_test.sv
module rtc_clock_cal_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  typedef struct packed {
    logic [7:0] rq;
    logic [7:0] s, m, h, w, d, mo, y;
    logic [7:0] n;
    logic [7:0] es, em, eh, ew, ed, emo, ey;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 8'h58,8'h59,8'h12,8'h03,8'h15,8'h06,8'h21, 8'd2, 8'h00,8'h00,8'h13,8'h03,8'h15,8'h06,8'h21}, // R2
    '{8'd2, 8'h59,8'h09,8'h05,8'h01,8'h01,8'h01,8'h00, 8'd1, 8'h00,8'h10,8'h05,8'h01,8'h01,8'h01,8'h00}, // R2
    '{8'd3, 8'h59,8'h59,8'h09,8'h02,8'h10,8'h03,8'h05, 8'd1, 8'h00,8'h00,8'h10,8'h02,8'h10,8'h03,8'h05}, // R3
    '{8'd7, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'd1, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, // R7 R3 R8
    '{8'd5, 8'h59,8'h59,8'h23,8'h02,8'h30,8'h04,8'h24, 8'd1, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h05,8'h24}, // R5
    '{8'd5, 8'h59,8'h59,8'h23,8'h02,8'h30,8'h05,8'h24, 8'd1, 8'h00,8'h00,8'h00,8'h03,8'h31,8'h05,8'h24}, // R5
    '{8'd5, 8'h59,8'h59,8'h23,8'h05,8'h30,8'h09,8'h31, 8'd1, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h10,8'h31}, // R5
    '{8'd5, 8'h59,8'h59,8'h23,8'h06,8'h30,8'h11,8'h31, 8'd1, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h12,8'h31}, // R5
    '{8'd6, 8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h24, 8'd1, 8'h00,8'h00,8'h00,8'h05,8'h29,8'h02,8'h24}, // R6
    '{8'd6, 8'h59,8'h59,8'h23,8'h04,8'h29,8'h02,8'h24, 8'd1, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h03,8'h24}, // R6
    '{8'd6, 8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h23, 8'd1, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h03,8'h23}, // R6
    '{8'd6, 8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h00, 8'd1, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h00}, // R6
    '{8'd6, 8'h59,8'h59,8'h23,8'h06,8'h28,8'h02,8'h12, 8'd1, 8'h00,8'h00,8'h00,8'h07,8'h29,8'h02,8'h12}, // R6
    '{8'd6, 8'h59,8'h59,8'h23,8'h07,8'h28,8'h02,8'h10, 8'd1, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h03,8'h10}, // R6 R8
    '{8'd4, 8'h59,8'h59,8'h51,8'h03,8'h09,8'h09,8'h09, 8'd1, 8'h00,8'h00,8'h72,8'h03,8'h09,8'h09,8'h09}, // R4
    '{8'd4, 8'h59,8'h59,8'h72,8'h03,8'h09,8'h09,8'h09, 8'd1, 8'h00,8'h00,8'h61,8'h03,8'h09,8'h09,8'h09}, // R4
    '{8'd4, 8'h59,8'h59,8'h71,8'h03,8'h09,8'h09,8'h09, 8'd1, 8'h00,8'h00,8'h52,8'h04,8'h10,8'h09,8'h09}, // R4
    '{8'd5, 8'h59,8'h59,8'h23,8'h01,8'h31,8'h01,8'h45, 8'd1, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h02,8'h45}, // R5
    '{8'd2, 8'h30,8'h15,8'h08,8'h02,8'h14,8'h07,8'h33, 8'd5, 8'h35,8'h15,8'h08,8'h02,8'h14,8'h07,8'h33}, // R2
    '{8'd7, 8'h59,8'h59,8'h23,8'h03,8'h31,8'h12,8'h19, 8'd1, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h01,8'h20}  // R7
  };

  logic       clk, rst_n, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sec, min, hour, dow, date, mon, year;
  int n_checks = 0;
  int n_fail = 0;

  rtc_clock_cal #(.TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow), .date_o(date), .mon_o(mon), .year_o(year)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_all(input string rq, input logic [7:0] es, em, eh, ew, ed, emo, ey);
    chk(rq, "sec", sec, es);   chk(rq, "min", min, em);   chk(rq, "hour", hour, eh);
    chk(rq, "dow", dow, ew);   chk(rq, "date", date, ed); chk(rq, "mon", mon, emo);
    chk(rq, "year", year, ey);
  endtask

  // Called at a negedge; the write lands on the next posedge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic secs(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired (R1 through R11 incomplete)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk_all("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    rst_n = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    chk("R1", "sec before first advance", sec, 8'h00);
    @(negedge clk);
    chk("R2", "sec after first advance", sec, 8'h01);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      wr(3'd0, 8'h80 | VECS[i].s);
      wr(3'd1, VECS[i].m);  wr(3'd2, VECS[i].h);  wr(3'd3, VECS[i].w);
      wr(3'd4, VECS[i].d);  wr(3'd5, VECS[i].mo); wr(3'd6, VECS[i].y);
      wr(3'd0, VECS[i].s);
      secs(int'(VECS[i].n));
      chk_all(rq, VECS[i].es, VECS[i].em, VECS[i].eh, VECS[i].ew, VECS[i].ed, VECS[i].emo, VECS[i].ey);
    end

    // R9: halt freezes everything, release resumes
    wr(3'd1, 8'h22);
    wr(3'd0, 8'h85);
    secs(3);
    chk("R9", "sec while halted", sec, 8'h85);
    chk("R9", "min while halted", min, 8'h22);
    wr(3'd0, 8'h05);
    secs(1);
    chk("R9", "sec after release", sec, 8'h06);

    // R10: address 7 changes nothing
    wr(3'd0, 8'h80 | 8'h17);
    wr(3'd7, 8'h33);
    chk_all("R10 addr7", 8'h97, 8'h22, 8'h00, 8'h04, 8'h01, 8'h01, 8'h20);

    // R10: advance coinciding with a minutes write is dropped
    wr(3'd0, 8'h10);
    repeat (DIV - 1) @(negedge clk);
    wr(3'd1, 8'h44);
    chk("R10", "sec after dropped advance", sec, 8'h10);
    chk("R10", "min written on advance cycle", min, 8'h44);
    repeat (DIV) @(negedge clk);
    chk("R10", "sec on next advance", sec, 8'h11);

    // R11: mid-second seconds write realigns the prescaler
    repeat (2) @(negedge clk);
    wr(3'd0, 8'h40);
    repeat (DIV - 1) @(negedge clk);
    chk("R11", "sec one cycle before advance", sec, 8'h40);
    @(negedge clk);
    chk("R11", "sec at advance", sec, 8'h41);

    // R1: asynchronous cold reset mid-run
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #(CLK_PERIOD/4);
    chk_all("R1 async", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule